// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Pulse Generator

This block is a clocked monostable with two independent channels that share one clock. Each channel has three control inputs: a trigger that acts on its falling edge, a trigger that acts on its rising edge, and an active-low clear. Each input gates the other two. When a channel accepts a trigger, its Q output goes high for a programmed number of clock cycles, and its Qn output always carries the complement of Q. A per-channel width input replaces the external timing network. The width is captured when a trigger is accepted, so a later change does not affect a pulse that is already running.

Every control input passes through a synchronizer chain, so the block may be driven from any clock domain. Edges are found by comparing the synchronized value with its value one cycle earlier. A trigger that is accepted while a pulse is running reloads the counter, so the pulse lasts a full width after the last trigger. Holding clear low stops any pulse and blocks all triggers. Releasing clear is itself a trigger when the other two inputs are in their enabling state.

Top module: `oneshot_dual`

## Requirements
- R1: A falling edge on `a_in[c]` starts a pulse on channel c when `b_in[c]` is 1 and `clr_n_in[c]` is 1 at that time.
- R2: A rising edge on `b_in[c]` starts a pulse on channel c when `a_in[c]` is 0 and `clr_n_in[c]` is 1.
- R3: A rising edge on `clr_n_in[c]` starts a pulse on channel c when `a_in[c]` is 0 and `b_in[c]` is 1.
- R4: While the synchronized `clr_n_in[c]` is 0, channel c's pulse is cut off (Q low from the third clock edge after clear is driven low) and no trigger is accepted.
- R5: At rest, `q_out[c]` is 0 and `qn_out[c]` is 1, and `qn_out[c]` is always the inverse of `q_out[c]`.
- R6: A trigger that is accepted while a pulse is running restarts the count, so Q stays high for the full width after the new trigger.
- R7: The pulse width N is read from `width_in[c*WIDTH_W +: WIDTH_W]` in the cycle the trigger is accepted. A later change does not alter the running pulse. A trigger accepted with N = 0 has no effect.
- R8: With two synchronizer stages, take an input change set up before clock edge E0. Q rises after edge E2 and stays high for exactly N clock cycles.
- R9: The channels are independent. A trigger on one channel leaves the other channel's outputs unchanged.
- R10: While `rst` is high at a clock edge, every counter clears, so Q is 0 and Qn is 1.
- R11: If clear is released in the same cycle that another input's enabling edge arrives, exactly one trigger is accepted.
- R12: Edges that are not qualified have no effect. Examples are a falling edge on A while B is 0, a rising edge on B while A is 1, a rising edge on A, and a falling edge on B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both channels |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | CHANNELS | Falling-edge trigger, one bit per channel |
| b_in | input | CHANNELS | Rising-edge trigger, one bit per channel |
| clr_n_in | input | CHANNELS | Active-low clear that also triggers on release, one bit per channel |
| width_in | input | CHANNELS*WIDTH_W | Pulse width in cycles, one field per channel |
| q_out | output | CHANNELS | Pulse output, active high |
| qn_out | output | CHANNELS | Inverse of q_out |

## Verification
The bench builds the block with two channels, a 4-bit width field and two synchronizer stages. This keeps every pulse short enough that each high cycle and the first low cycle after it can be checked one by one. Two channels are enough to show that stimulus on one channel leaves the other unchanged, and that both channels can fire together with different widths. A width of 1 tests the shortest pulse. A width of 0 tests a trigger that is accepted but has no effect.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Levels of one channel's three control inputs
    typedef struct packed {
        logic a;
        logic b;
        logic clr_n;
    } ctl_t;

    // Edge flags found between two consecutive samples
    typedef struct packed {
        logic a_fall;
        logic b_rise;
        logic clr_rise;
    } edges_t;

    // Inert resting levels used by reset
    localparam ctl_t CTL_REST = '{a: 1'b1, b: 1'b0, clr_n: 1'b1};

    function automatic edges_t find_edges(ctl_t prev, ctl_t cur);
        edges_t e;
        e.a_fall   = prev.a & ~cur.a;
        e.b_rise   = ~prev.b & cur.b;
        e.clr_rise = ~prev.clr_n & cur.clr_n;
        return e;
    endfunction

    // All three inputs sit in their enabling state
    function automatic logic enabled(ctl_t c);
        return c.clr_n & ~c.a & c.b;
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync
    import oneshot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t raw,
    output ctl_t cur,
    output ctl_t prev
);
    localparam int LAST = STAGES - 1;

    ctl_t stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= CTL_REST;
            prev <= CTL_REST;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[LAST];
        end
    end

    assign cur = stg[LAST];

endmodule

// File: rtl/trig_qual.sv
module trig_qual
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t cur,
    input  ctl_t prev,
    output logic fire
);
    edges_t ev;

    always_comb begin
        ev   = find_edges(prev, cur);
        fire = enabled(cur) & (ev.a_fall | ev.b_rise | ev.clr_rise);
    end

    // R4: no trigger while clear is held low
    a_r4_inhibit: assert property (@(posedge clk) disable iff (rst)
        !cur.clr_n |-> !fire);

    // R11: one event never yields triggers in back-to-back cycles
    a_r11_one_fire: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R12: a rising edge on A never triggers
    a_r12_a_rise_inert: assert property (@(posedge clk) disable iff (rst)
        (!prev.a && cur.a) |-> !fire);

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_n,
    input  logic               fire,
    input  logic [WIDTH_W-1:0] width,
    output logic               q
);
    localparam logic [WIDTH_W-1:0] ZERO = '0;

    logic [WIDTH_W-1:0] cnt;
    logic               load;

    assign load = fire && (width != ZERO);

    always_ff @(posedge clk) begin
        if (rst || !clr_n) begin
            cnt <= ZERO;
        end else if (load) begin
            cnt <= width;
        end else if (cnt != ZERO) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign q = (cnt != ZERO);

    // R4: clear low terminates the pulse at the next edge
    a_r4_clear_ends: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> !q);

    // R6: an accepted trigger reloads the full width
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        (fire && clr_n && width != ZERO) |=> (cnt == $past(width)));

    // R7: zero width from idle leaves the output low
    a_r7_zero_width: assert property (@(posedge clk) disable iff (rst)
        (fire && clr_n && width == ZERO && cnt == ZERO) |=> !q);

    // R8: a running pulse with more than one cycle left stays high
    a_r8_hold_high: assert property (@(posedge clk) disable iff (rst)
        (clr_n && cnt > 1) |=> q);

endmodule

// File: rtl/oneshot_dual.sv
module oneshot_dual
    import oneshot_pkg::*;
#(
    parameter int CHANNELS    = 2,
    parameter int WIDTH_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CHANNELS-1:0]           a_in,
    input  logic [CHANNELS-1:0]           b_in,
    input  logic [CHANNELS-1:0]           clr_n_in,
    input  logic [CHANNELS*WIDTH_W-1:0]   width_in,
    output logic [CHANNELS-1:0]           q_out,
    output logic [CHANNELS-1:0]           qn_out
);

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        ctl_t raw, cur, prev;
        logic fire;
        logic q;

        assign raw = '{a: a_in[c], b: b_in[c], clr_n: clr_n_in[c]};

        ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw),
            .cur  (cur),
            .prev (prev)
        );

        trig_qual u_qual (
            .clk  (clk),
            .rst  (rst),
            .cur  (cur),
            .prev (prev),
            .fire (fire)
        );

        pulse_timer #(.WIDTH_W(WIDTH_W)) u_timer (
            .clk   (clk),
            .rst   (rst),
            .clr_n (cur.clr_n),
            .fire  (fire),
            .width (width_in[c*WIDTH_W +: WIDTH_W]),
            .q     (q)
        );

        assign q_out[c]  = q;
        assign qn_out[c] = ~q;

        // R5: after reset the output is low until a trigger is accepted
        a_r5_rest_low: assert property (@(posedge clk) disable iff (rst)
            ($past(rst) && !fire) |=> !q_out[c]);
    end

endmodule

// File: tb/oneshot_dual_tb_top.sv
module oneshot_dual_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CHANNELS   = 2;
    localparam int WIDTH_W    = 4;

    logic                        clk = 1'b0;
    logic                        rst;
    logic [CHANNELS-1:0]         a_in, b_in, clr_n_in;
    logic [CHANNELS*WIDTH_W-1:0] width_in;
    logic [CHANNELS-1:0]         q_out, qn_out;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        int    at;
        int    ch;
        bit    val;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    oneshot_dual #(.CHANNELS(CHANNELS), .WIDTH_W(WIDTH_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .clr_n_in(clr_n_in),
        .width_in(width_in), .q_out(q_out), .qn_out(qn_out)
    );

    // Monitor: compare outputs with queued expectations (R5 checks Qn each time)
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                if (sb_q[i].at == cyc) begin
                    n_checks++;
                    if (q_out[sb_q[i].ch] !== sb_q[i].val ||
                        qn_out[sb_q[i].ch] !== ~sb_q[i].val) begin
                        n_fail++;
                        $display("FAIL %s/R5 ch%0d cycle %0d: q=%b qn=%b expected q=%b qn=%b",
                                 sb_q[i].tag, sb_q[i].ch, cyc, q_out[sb_q[i].ch],
                                 qn_out[sb_q[i].ch], sb_q[i].val, ~sb_q[i].val);
                    end
                    sb_q.delete(i);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_level(int ch, int from, int upto, bit v, string tag);
        for (int t = from; t <= upto; t++) begin
            exp_t e;
            e.at = t; e.ch = ch; e.val = v; e.tag = tag;
            sb_q.push_back(e);
        end
    endtask

    // Trigger driven at cycle t0: high t0+3 .. t0+2+n, low at t0+3+n
    task automatic expect_pulse(int ch, int t0, int n, string tag);
        expect_level(ch, t0 + 3, t0 + 2 + n, 1'b1, tag);
        expect_level(ch, t0 + 3 + n, t0 + 3 + n, 1'b0, tag);
    endtask

    task automatic set_width(int ch, int n);
        width_in[ch*WIDTH_W +: WIDTH_W] = WIDTH_W'(n);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 20000", cyc);
        summary();
        $finish;
    end

    initial begin
        int t0;
        rst = 1'b1;
        a_in = '1; b_in = '0; clr_n_in = '1;
        width_in = '0;
        set_width(0, 5); set_width(1, 3);
        tick(3);
        // R10 / R5: reset state
        for (int c = 0; c < CHANNELS; c++) begin
            n_checks++;
            if (q_out[c] !== 1'b0 || qn_out[c] !== 1'b1) begin
                n_fail++;
                $display("FAIL R10 ch%0d: q=%b qn=%b expected q=0 qn=1", c, q_out[c], qn_out[c]);
            end
        end
        rst = 1'b0;
        tick(4);

        // R12: B rises while A high -> nothing
        b_in[0] = 1'b1; t0 = cyc;
        expect_level(0, t0 + 1, t0 + 6, 1'b0, "R12");
        tick(6);
        // R1: A falls with B high
        a_in[0] = 1'b0; t0 = cyc;
        expect_pulse(0, t0, 5, "R1");
        expect_level(1, t0, t0 + 10, 1'b0, "R9");
        tick(10);
        a_in[0] = 1'b1; t0 = cyc;           // R12: A rise inert
        expect_level(0, t0 + 1, t0 + 4, 1'b0, "R12");
        tick(1);
        b_in[0] = 1'b0;                     // R12: B fall inert
        tick(5);

        // R12: A falls while B low -> nothing
        a_in[0] = 1'b0; t0 = cyc;
        expect_level(0, t0 + 1, t0 + 5, 1'b0, "R12");
        tick(5);
        // R2: B rises with A low
        b_in[0] = 1'b1; t0 = cyc;
        expect_pulse(0, t0, 5, "R2");
        tick(10);
        b_in[0] = 1'b0; tick(1);
        a_in[0] = 1'b1; tick(4);

        // R4: triggers inhibited under clear, R3: release fires
        clr_n_in[0] = 1'b0; tick(1);
        a_in[0] = 1'b0; tick(1);
        b_in[0] = 1'b1; t0 = cyc;
        expect_level(0, t0, t0 + 6, 1'b0, "R4");
        tick(6);
        clr_n_in[0] = 1'b1; t0 = cyc;
        expect_pulse(0, t0, 5, "R3");
        tick(10);

        // R6: retrigger restarts the count
        a_in[0] = 1'b1; tick(3);
        a_in[0] = 1'b0; t0 = cyc;
        expect_level(0, t0 + 3, t0 + 6, 1'b1, "R6");
        expect_pulse(0, t0 + 4, 5, "R6");
        tick(3);
        a_in[0] = 1'b1; tick(1);
        a_in[0] = 1'b0;
        tick(12);

        // R7: zero width ignored
        set_width(0, 0);
        a_in[0] = 1'b1; tick(3);
        a_in[0] = 1'b0; t0 = cyc;
        expect_level(0, t0 + 1, t0 + 8, 1'b0, "R7");
        tick(8);
        // R7: width sampled at acceptance only
        set_width(0, 4);
        a_in[0] = 1'b1; tick(3);
        a_in[0] = 1'b0; t0 = cyc;
        expect_pulse(0, t0, 4, "R7");
        tick(3);
        set_width(0, 9);
        tick(8);

        // R8: single-cycle pulse timing
        set_width(0, 1);
        a_in[0] = 1'b1; tick(3);
        a_in[0] = 1'b0; t0 = cyc;
        expect_level(0, t0 + 2, t0 + 2, 1'b0, "R8");
        expect_pulse(0, t0, 1, "R8");
        tick(6);

        // R4: clear cuts a running pulse, toggles under clear are inert
        set_width(0, 5);
        a_in[0] = 1'b1; tick(3);
        a_in[0] = 1'b0; t0 = cyc;
        tick(3);
        clr_n_in[0] = 1'b0;
        expect_level(0, t0 + 3, t0 + 5, 1'b1, "R4");
        expect_level(0, t0 + 6, t0 + 17, 1'b0, "R4");
        tick(2); a_in[0] = 1'b1;
        tick(2); a_in[0] = 1'b0;
        tick(6); a_in[0] = 1'b1;
        tick(1); clr_n_in[0] = 1'b1;
        tick(5);

        // R11: clear release together with A fall -> one pulse
        clr_n_in[0] = 1'b0; tick(4);
        clr_n_in[0] = 1'b1; a_in[0] = 1'b0; t0 = cyc;
        expect_pulse(0, t0, 5, "R11");
        expect_level(0, t0 + 9, t0 + 10, 1'b0, "R11");
        tick(11);

        // R9: channel 1 alone, then both with different widths
        b_in[1] = 1'b1; tick(1);
        a_in[1] = 1'b0; t0 = cyc;
        expect_pulse(1, t0, 3, "R9");
        expect_level(0, t0, t0 + 8, 1'b0, "R9");
        tick(8);
        a_in = 2'b11; tick(3);
        a_in = 2'b00; t0 = cyc;
        expect_pulse(0, t0, 5, "R9");
        expect_pulse(1, t0, 3, "R9");
        tick(12);

        tick(5);
        while (sb_q.size() > 0) begin
            n_checks++; n_fail++;
            $display("FAIL %s ch%0d: expectation for cycle %0d never sampled, actual none expected q=%b",
                     sb_q[0].tag, sb_q[0].ch, sb_q[0].at, sb_q[0].val);
            void'(sb_q.pop_front());
        end
        summary();
        $finish;
    end

endmodule